// File: doc/BRIEF.md
# CAN Message Object Status Flags

This block keeps one status byte for each message object of a CAN controller (15 objects by default). A protocol engine reports completed transfers and detected errors as single-cycle event pulses. Each pulse carries its kind, where it happened in the frame (an end-of-frame flag and a bit index within that field), and a mask of the objects it could belong to. The block accepts completion events only at their exact end-of-frame bit. It hands each accepted event to the lowest-indexed object in the mask and sets that object's sticky flag.

A receive completion also loads the received data length code into the object. When the new length differs from the one already stored, it raises a length warning. Software reads a status byte, then writes it back with zeros in the bits it wants cleared. A snapshot taken at the read makes sure the write-back only clears flags that software actually saw. A single registered interrupt line combines the interrupt-capable flags of every object whose enable is set.

Top module: `canmob_status`

## Requirements
- R1: During and right after a synchronous active-high reset, `rd_stat`, `rd_dlc` and `irq` are 0. The status bytes and stored lengths are not cleared by reset.
- R2: Status byte bit positions: 7 length warning, 6 transmit done, 5 receive done, 4 bit error, 3 stuff error, 2 CRC error, 1 form error, 0 acknowledge error. A `sw_rd` pulse with a valid `sw_sel` (0 to 14) shows that object's byte and length on `rd_stat`/`rd_dlc` one clock later.
- R3: Event kind code 0 (transmit done) is accepted only when `ev_eof`=1 and `ev_pos`=6. At any other position it changes nothing.
- R4: Event kind code 1 (receive done) is accepted only when `ev_eof`=1 and `ev_pos`=5. At position 6, or outside end-of-frame, it changes nothing.
- R5: An accepted event goes only to the lowest set bit of `ev_objs`. An empty mask, or kind code 7, changes nothing.
- R6: An accepted receive done loads `ev_dlc` into the object's stored length. It also sets bit 7 if the old stored length differed, and leaves bit 7 alone if it was equal.
- R7: Kind codes 2..6 (bit, stuff, CRC, form, acknowledge error) set bits 4..0 respectively, at any frame position.
- R8: `sw_wr_stat` clears exactly the bits that are written as 0 and were set in the byte returned by the object's last read. Writing 1 never sets a flag. A write with no read since the previous write clears nothing.
- R9: A flag whose event is accepted in the same cycle as a write-back to the same object ends up set.
- R10: `irq` is registered. One clock after a change, it equals the OR over objects of (`obj_ien` bit AND any of status bits 6..1). Bits 7 and 0 never raise it.
- R11: `sw_wr_dlc` writes `sw_wdata[3:0]` into the selected object's stored length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event pulse from the protocol engine |
| ev_kind | input | 3 | Event kind code (0..6 used, 7 ignored) |
| ev_eof | input | 1 | Event happened inside the end-of-frame field |
| ev_pos | input | 3 | Bit index within the current field |
| ev_objs | input | 15 | Candidate objects (enabled producers or receive hits) |
| ev_dlc | input | 4 | Received data length code |
| sw_sel | input | 4 | Object selected by software access |
| sw_rd | input | 1 | Read strobe; also captures the clear snapshot |
| sw_wr_stat | input | 1 | Status write-back strobe |
| sw_wr_dlc | input | 1 | Stored length write strobe |
| sw_wdata | input | 8 | Write data |
| obj_ien | input | 15 | Per-object interrupt enable |
| rd_stat | output | 8 | Registered status byte of the last read |
| rd_dlc | output | 4 | Registered stored length of the last read |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a flag that sets between software's read and its write-back. That window is only a few cycles long. The stimulus holds it open on purpose: it reads an object, injects an event into that same object, and then writes back zeros. In a separate step it issues the write-back and the event in the very same cycle. A scoreboard model of the flags then checks that neither the unseen flag nor the racing one was lost.

// File: rtl/canmob_pkg.sv
package canmob_pkg;

  typedef enum logic [2:0] {
    EV_TXOK = 3'd0,
    EV_RXOK = 3'd1,
    EV_BERR = 3'd2,
    EV_SERR = 3'd3,
    EV_CERR = 3'd4,
    EV_FERR = 3'd5,
    EV_AERR = 3'd6,
    EV_RSVD = 3'd7
  } ev_kind_e;

  localparam int STAT_W   = 8;
  localparam int B_DLCW   = 7;
  localparam int B_TXOK   = 6;
  localparam int B_RXOK   = 5;
  localparam int B_BERR   = 4;
  localparam int B_SERR   = 3;
  localparam int B_CERR   = 2;
  localparam int B_FERR   = 1;
  localparam int B_AERR   = 0;

  // flags allowed to request an interrupt
  localparam logic [STAT_W-1:0] IRQ_CAPABLE = 8'b0111_1110;

endpackage

// File: rtl/canmob_pick.sv
module canmob_pick #(
  parameter int N = 15
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);

  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign any = |req;

  // R5
  always_comb begin
    grant_onehot_chk: assert ($onehot0(grant));
  end

endmodule

// File: rtl/canmob_route.sv
module canmob_route
  import canmob_pkg::*;
#(
  parameter int NOBJ        = 15,
  parameter int POS_W       = 3,
  parameter int TX_DONE_BIT = 6,
  parameter int RX_DONE_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [2:0]        ev_kind,
  input  logic              ev_eof,
  input  logic [POS_W-1:0]  ev_pos,
  input  logic [NOBJ-1:0]   ev_objs,
  output logic [NOBJ-1:0]   obj_hit,
  output logic [STAT_W-1:0] set_bits,
  output logic              rx_load
);

  ev_kind_e        kind;
  logic            accept;
  logic            any_req;
  logic [NOBJ-1:0] grant;
  logic            at_tx_end;
  logic            at_rx_end;

  assign kind      = ev_kind_e'(ev_kind);
  assign at_tx_end = ev_eof && (ev_pos == POS_W'(TX_DONE_BIT));
  assign at_rx_end = ev_eof && (ev_pos == POS_W'(RX_DONE_BIT));

  canmob_pick #(.N(NOBJ)) pick_i (
    .req   (ev_objs),
    .grant (grant),
    .any   (any_req)
  );

  always_comb begin
    accept   = 1'b0;
    set_bits = '0;
    case (kind)
      EV_TXOK: begin accept = at_tx_end; set_bits[B_TXOK] = 1'b1; end
      EV_RXOK: begin accept = at_rx_end; set_bits[B_RXOK] = 1'b1; end
      EV_BERR: begin accept = 1'b1;      set_bits[B_BERR] = 1'b1; end
      EV_SERR: begin accept = 1'b1;      set_bits[B_SERR] = 1'b1; end
      EV_CERR: begin accept = 1'b1;      set_bits[B_CERR] = 1'b1; end
      EV_FERR: begin accept = 1'b1;      set_bits[B_FERR] = 1'b1; end
      EV_AERR: begin accept = 1'b1;      set_bits[B_AERR] = 1'b1; end
      default: begin accept = 1'b0;      set_bits = '0;           end
    endcase
  end

  assign obj_hit = (ev_valid && accept && any_req) ? grant : '0;
  assign rx_load = ev_valid && accept && any_req && (kind == EV_RXOK);

  // R3
  tx_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 3'd0 && !(ev_eof && ev_pos == POS_W'(TX_DONE_BIT)))
      |-> (obj_hit == '0));

  // R4
  rx_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 3'd1 && !(ev_eof && ev_pos == POS_W'(RX_DONE_BIT)))
      |-> (obj_hit == '0 && !rx_load));

  // R5
  hit_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ((obj_hit & ~ev_objs) == '0) && $onehot0(obj_hit));

endmodule

// File: rtl/canmob_bank.sv
module canmob_bank
  import canmob_pkg::*;
#(
  parameter int NOBJ  = 15,
  parameter int DLC_W = 4,
  parameter int SELW  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NOBJ-1:0]              obj_hit,
  input  logic [STAT_W-1:0]            set_bits,
  input  logic                         rx_load,
  input  logic [DLC_W-1:0]             ev_dlc,
  input  logic [SELW-1:0]              sw_sel,
  input  logic                         sw_rd,
  input  logic                         sw_wr_stat,
  input  logic                         sw_wr_dlc,
  input  logic [STAT_W-1:0]            sw_wdata,
  output logic [NOBJ-1:0][STAT_W-1:0]  stat_all,
  output logic [STAT_W-1:0]            rd_stat,
  output logic [DLC_W-1:0]             rd_dlc
);

  localparam logic [STAT_W-1:0] DLCW_MASK = STAT_W'(1) << B_DLCW;

  logic [NOBJ-1:0][DLC_W-1:0] dlc_all;
  logic                       sel_ok;

  assign sel_ok = (int'(sw_sel) < NOBJ);

  for (genvar g = 0; g < NOBJ; g++) begin : g_obj
    logic              sel_g;
    logic [STAT_W-1:0] stat_r;
    logic [STAT_W-1:0] snap_r;
    logic [DLC_W-1:0]  dlc_r;
    logic [STAT_W-1:0] set_g;
    logic [STAT_W-1:0] keep_g;

    assign sel_g  = sel_ok && (sw_sel == SELW'(g));
    assign set_g  = obj_hit[g]
                  ? (set_bits | ((rx_load && ev_dlc != dlc_r) ? DLCW_MASK : '0))
                  : '0;
    assign keep_g = (sel_g && sw_wr_stat) ? (sw_wdata | ~snap_r) : '1;

    // status byte: no reset, events win over the clear
    always_ff @(posedge clk) begin
      stat_r <= (stat_r & keep_g) | set_g;
    end

    always_ff @(posedge clk) begin
      if (obj_hit[g] && rx_load) dlc_r <= ev_dlc;
      else if (sel_g && sw_wr_dlc) dlc_r <= sw_wdata[DLC_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst) snap_r <= '0;
      else if (sel_g && sw_rd) snap_r <= stat_r;
      else if (sel_g && sw_wr_stat) snap_r <= '0;
    end

    assign stat_all[g] = stat_r;
    assign dlc_all[g]  = dlc_r;

    // R9
    event_sticks_chk: assert property (@(posedge clk) disable iff (rst)
      obj_hit[g] |=> ((stat_r & $past(set_bits)) == $past(set_bits)));

    // R8
    clear_seen_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_g && sw_wr_stat && !obj_hit[g])
        |=> ((stat_r & ~$past(sw_wdata) & $past(snap_r)) == '0));

    // R6
    dlc_load_chk: assert property (@(posedge clk) disable iff (rst)
      (obj_hit[g] && rx_load) |=> (dlc_r == $past(ev_dlc)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stat <= '0;
      rd_dlc  <= '0;
    end else if (sw_rd && sel_ok) begin
      rd_stat <= stat_all[sw_sel];
      rd_dlc  <= dlc_all[sw_sel];
    end
  end

endmodule

// File: rtl/canmob_irq.sv
module canmob_irq
  import canmob_pkg::*;
#(
  parameter int NOBJ = 15
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NOBJ-1:0][STAT_W-1:0] stat_all,
  input  logic [NOBJ-1:0]             obj_ien,
  output logic                        irq
);

  logic [NOBJ-1:0] pend;

  for (genvar g = 0; g < NOBJ; g++) begin : g_pend
    assign pend[g] = obj_ien[g] && (|(stat_all[g] & IRQ_CAPABLE));
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |pend;
  end

  // R1
  irq_reset_chk: assert property (@(posedge clk) rst |=> !irq);

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (obj_ien == '0) |=> !irq);

endmodule

// File: rtl/canmob_status.sv
module canmob_status
  import canmob_pkg::*;
#(
  parameter int NOBJ        = 15,
  parameter int DLC_W       = 4,
  parameter int POS_W       = 3,
  parameter int TX_DONE_BIT = 6,
  parameter int RX_DONE_BIT = 5,
  localparam int SELW       = $clog2(NOBJ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [2:0]        ev_kind,
  input  logic              ev_eof,
  input  logic [POS_W-1:0]  ev_pos,
  input  logic [NOBJ-1:0]   ev_objs,
  input  logic [DLC_W-1:0]  ev_dlc,
  input  logic [SELW-1:0]   sw_sel,
  input  logic              sw_rd,
  input  logic              sw_wr_stat,
  input  logic              sw_wr_dlc,
  input  logic [STAT_W-1:0] sw_wdata,
  input  logic [NOBJ-1:0]   obj_ien,
  output logic [STAT_W-1:0] rd_stat,
  output logic [DLC_W-1:0]  rd_dlc,
  output logic              irq
);

  logic [NOBJ-1:0]             obj_hit;
  logic [STAT_W-1:0]           set_bits;
  logic                        rx_load;
  logic [NOBJ-1:0][STAT_W-1:0] stat_all;

  canmob_route #(
    .NOBJ(NOBJ), .POS_W(POS_W),
    .TX_DONE_BIT(TX_DONE_BIT), .RX_DONE_BIT(RX_DONE_BIT)
  ) route_i (
    .clk(clk), .rst(rst),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_eof(ev_eof),
    .ev_pos(ev_pos), .ev_objs(ev_objs),
    .obj_hit(obj_hit), .set_bits(set_bits), .rx_load(rx_load)
  );

  canmob_bank #(.NOBJ(NOBJ), .DLC_W(DLC_W), .SELW(SELW)) bank_i (
    .clk(clk), .rst(rst),
    .obj_hit(obj_hit), .set_bits(set_bits), .rx_load(rx_load), .ev_dlc(ev_dlc),
    .sw_sel(sw_sel), .sw_rd(sw_rd), .sw_wr_stat(sw_wr_stat),
    .sw_wr_dlc(sw_wr_dlc), .sw_wdata(sw_wdata),
    .stat_all(stat_all), .rd_stat(rd_stat), .rd_dlc(rd_dlc)
  );

  canmob_irq #(.NOBJ(NOBJ)) irq_i (
    .clk(clk), .rst(rst),
    .stat_all(stat_all), .obj_ien(obj_ien), .irq(irq)
  );

endmodule

// File: tb/canmob_status_tb_top.sv
module canmob_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NOBJ = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic [2:0]  ev_kind = '0;
  logic        ev_eof = 1'b0;
  logic [2:0]  ev_pos = '0;
  logic [14:0] ev_objs = '0;
  logic [3:0]  ev_dlc = '0;
  logic [3:0]  sw_sel = '0;
  logic        sw_rd = 1'b0;
  logic        sw_wr_stat = 1'b0;
  logic        sw_wr_dlc = 1'b0;
  logic [7:0]  sw_wdata = '0;
  logic [14:0] obj_ien = '0;
  logic [7:0]  rd_stat;
  logic [3:0]  rd_dlc;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  canmob_status dut_i (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_eof(ev_eof), .ev_pos(ev_pos), .ev_objs(ev_objs), .ev_dlc(ev_dlc),
    .sw_sel(sw_sel), .sw_rd(sw_rd), .sw_wr_stat(sw_wr_stat),
    .sw_wr_dlc(sw_wr_dlc), .sw_wdata(sw_wdata), .obj_ien(obj_ien),
    .rd_stat(rd_stat), .rd_dlc(rd_dlc), .irq(irq)
  );

  typedef struct {
    logic [7:0] stat;
    logic [3:0] dlc;
    string      req;
    bit         chk;
  } exp_t;

  exp_t       expq[$];
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;
  logic [7:0] mstat [NOBJ];
  logic [7:0] msnap [NOBJ];
  logic [3:0] mdlc  [NOBJ];
  logic       rd_seen = 1'b0;

  // scoreboard monitor
  always @(posedge clk) rd_seen <= sw_rd;

  always @(negedge clk) begin
    exp_t e;
    if (rd_seen) begin
      if (expq.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: read with no expected item, actual=%h expected=none", rd_stat);
      end else begin
        e = expq.pop_front();
        if (e.chk) begin
          total++;
          if (rd_stat !== e.stat || rd_dlc !== e.dlc) begin
            bad++;
            $display("FAIL %s: actual stat=%h dlc=%h expected stat=%h dlc=%h",
                     e.req, rd_stat, rd_dlc, e.stat, e.dlc);
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    ev_valid = 1'b0; sw_rd = 1'b0; sw_wr_stat = 1'b0; sw_wr_dlc = 1'b0;
  endtask

  // drivers: each updates the model in the same cycle order as the requirements
  task automatic drive_rd(input int s, input bit chk, input string req);
    exp_t e;
    e.stat = mstat[s]; e.dlc = mdlc[s]; e.req = req; e.chk = chk;
    expq.push_back(e);
    msnap[s] = mstat[s];
    sw_sel = 4'(s); sw_rd = 1'b1;
  endtask

  task automatic drive_wr(input int s, input logic [7:0] wd);
    mstat[s] = mstat[s] & (wd | ~msnap[s]);
    msnap[s] = '0;
    sw_sel = 4'(s); sw_wdata = wd; sw_wr_stat = 1'b1;
  endtask

  task automatic drive_dlc(input int s, input logic [3:0] d);
    mdlc[s] = d;
    sw_sel = 4'(s); sw_wdata = {4'h0, d}; sw_wr_dlc = 1'b1;
  endtask

  task automatic drive_ev(input logic [2:0] k, input logic eof, input logic [2:0] pos,
                          input logic [14:0] objs, input logic [3:0] d);
    bit acc;
    int idx;
    acc = 1'b0; idx = -1;
    case (k)
      3'd0: acc = eof && pos == 3'd6;        // R3
      3'd1: acc = eof && pos == 3'd5;        // R4
      3'd2, 3'd3, 3'd4, 3'd5, 3'd6: acc = 1'b1; // R7
      default: acc = 1'b0;
    endcase
    for (int i = NOBJ - 1; i >= 0; i--) if (objs[i]) idx = i; // R5
    if (acc && idx >= 0) begin
      mstat[idx][6 - int'(k)] = 1'b1;
      if (k == 3'd1) begin                   // R6
        if (mdlc[idx] != d) mstat[idx][7] = 1'b1;
        mdlc[idx] = d;
      end
    end
    ev_valid = 1'b1; ev_kind = k; ev_eof = eof; ev_pos = pos; ev_objs = objs; ev_dlc = d;
  endtask

  task automatic rd(input int s, input string req);
    drive_rd(s, 1'b1, req); tick();
  endtask

  task automatic check_irq(input string req);
    logic exp_irq;
    @(negedge clk);
    exp_irq = 1'b0;
    for (int i = 0; i < NOBJ; i++)
      if (obj_ien[i] && (mstat[i] & 8'h7E) != 0) exp_irq = 1'b1;
    check(irq === exp_irq, req, {7'd0, irq}, {7'd0, exp_irq});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state of the registered outputs
    check(rd_stat === 8'h00, "R1 rd_stat", rd_stat, 8'h00);
    check(rd_dlc === 4'h0, "R1 rd_dlc", {4'h0, rd_dlc}, 8'h00);
    check(irq === 1'b0, "R1 irq", {7'd0, irq}, 8'h00);

    // bring undefined storage to a known state through the ports
    for (int i = 0; i < NOBJ; i++) begin
      drive_rd(i, 1'b0, "init"); tick();
      drive_wr(i, 8'h00); tick();
      drive_dlc(i, 4'h0); tick();
      mstat[i] = '0; msnap[i] = '0; mdlc[i] = '0;
    end
    for (int i = 0; i < NOBJ; i++) rd(i, "R2 cleared");

    // R3: transmit done only at end-of-frame bit 6
    drive_ev(3'd0, 1'b1, 3'd3, 15'h0006, 4'd0); tick();
    drive_ev(3'd0, 1'b0, 3'd6, 15'h0006, 4'd0); tick();
    drive_ev(3'd0, 1'b1, 3'd5, 15'h0006, 4'd0); tick();
    rd(1, "R3 off-position ignored");
    drive_ev(3'd0, 1'b1, 3'd6, 15'h0006, 4'd0); tick();
    rd(1, "R3 R5 lowest producer");
    rd(2, "R5 higher producer untouched");

    // R4: receive done only at end-of-frame bit 5
    drive_ev(3'd1, 1'b1, 3'd6, 15'h0088, 4'd8); tick();
    rd(3, "R4 seventh bit ignored");
    drive_ev(3'd1, 1'b1, 3'd5, 15'h0088, 4'd8); tick();
    rd(3, "R4 R6 receive with new length");
    rd(7, "R5 second hit untouched");

    // R6: equal length gives no warning
    drive_rd(3, 1'b1, "R8 pre-clear"); tick();
    drive_wr(3, 8'h00); tick();
    rd(3, "R8 cleared");
    drive_ev(3'd1, 1'b1, 3'd5, 15'h0008, 4'd8); tick();
    rd(3, "R6 equal length");

    // R11 then R6 against software length
    drive_dlc(6, 4'd5); tick();
    rd(6, "R11 length write");
    drive_ev(3'd1, 1'b1, 3'd5, 15'h0040, 4'd5); tick();
    rd(6, "R6 matches written length");
    drive_ev(3'd1, 1'b1, 3'd5, 15'h0040, 4'd2); tick();
    rd(6, "R6 mismatch warns and loads");

    // R7: errors at assorted positions
    drive_ev(3'd2, 1'b0, 3'd2, 15'h4000, 4'd0); tick();
    drive_ev(3'd3, 1'b1, 3'd7, 15'h4000, 4'd0); tick();
    drive_ev(3'd4, 1'b0, 3'd0, 15'h4000, 4'd0); tick();
    drive_ev(3'd5, 1'b1, 3'd1, 15'h4000, 4'd0); tick();
    drive_ev(3'd6, 1'b0, 3'd4, 15'h4000, 4'd0); tick();
    rd(14, "R7 all error flags");

    // R5: reserved kind and empty mask are ignored
    drive_ev(3'd7, 1'b1, 3'd5, 15'h0001, 4'd0); tick();
    drive_ev(3'd2, 1'b0, 3'd0, 15'h0000, 4'd0); tick();
    rd(0, "R5 reserved/empty ignored");
    drive_ev(3'd1, 1'b1, 3'd5, 15'h6000, 4'd3); tick();
    rd(13, "R5 lowest receive hit");
    drive_ev(3'd4, 1'b0, 3'd0, 15'h7FFF, 4'd0); tick();
    rd(0, "R5 error to index 0");

    // R10: interrupt combination
    obj_ien = 15'h4000;
    check_irq("R10 capable flags raise irq");
    drive_rd(14, 1'b1, "R8 read before clear"); tick();
    drive_wr(14, 8'h01); tick();
    check_irq("R10 acknowledge flag alone no irq");
    rd(14, "R8 partial clear");
    drive_rd(6, 1'b1, "R8 read obj6"); tick();
    drive_wr(6, 8'h80); tick();
    obj_ien = 15'h0040;
    check_irq("R10 length warning alone no irq");
    obj_ien = 15'h0008;
    check_irq("R10 receive done raises irq");
    obj_ien = 15'h0000;

    // R8: unseen flag survives, ones never set
    drive_rd(9, 1'b1, "R8 read obj9"); tick();
    drive_ev(3'd0, 1'b1, 3'd6, 15'h0200, 4'd0); tick();
    drive_wr(9, 8'h00); tick();
    rd(9, "R8 unseen flag kept");
    drive_wr(9, 8'hFF); tick();
    drive_wr(9, 8'h00); tick();
    rd(9, "R8 write without read clears nothing");
    drive_rd(9, 1'b1, "R8 reread"); tick();
    drive_wr(9, 8'h00); tick();
    rd(9, "R8 seen flag cleared");
    drive_rd(10, 1'b1, "R8 read obj10"); tick();
    drive_wr(10, 8'hFF); tick();
    rd(10, "R8 ones do not set");

    // R9: event and write-back in the same cycle
    drive_ev(3'd0, 1'b1, 3'd6, 15'h0010, 4'd0); tick();
    drive_rd(4, 1'b1, "R9 read obj4"); tick();
    drive_wr(4, 8'h00);
    drive_ev(3'd0, 1'b1, 3'd6, 15'h0010, 4'd0); tick();
    rd(4, "R9 same flag kept");
    drive_rd(4, 1'b1, "R9 reread"); tick();
    drive_wr(4, 8'h00);
    drive_ev(3'd2, 1'b0, 3'd3, 15'h0010, 4'd0); tick();
    rd(4, "R9 other flag kept");

    repeat (3) tick();
    check(expq.size() == 0, "R2 scoreboard drained", 8'(expq.size()), 8'h00);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule